// File: doc/BRIEF.md
# Split-Burst Read Response Merger

When an interconnect splits one master read burst into pieces that go to different memory controllers, each controller returns its piece as a separate read-data stream. These streams can arrive at the same time and interleave in any timing pattern. This block rebuilds them into one master-side burst. The master sees its beats in the original address order, with a single last-beat marker and one combined response code, so the split is invisible to it.

The splitting side pushes one descriptor per piece into a small in-order queue. A descriptor holds the controller that owns the piece, the piece's beat count and a flag that marks the closing piece of the burst. The merger accepts beats only from the controller named by the queue head and holds every other controller back. When the head piece has delivered its counted beats, the merger moves on to the next descriptor.

The queue is also the check on what each controller reports as its piece length. A controller that raises its last flag on a different beat than the descriptor predicts sets a sticky error flag. Only reset clears that flag.

Top module: `split_read_merger`

## Requirements
- R1: While reset is asserted and right after it: `m_valid_o`=0, `err_o`=0, `req_ready_o`=1, and every bit of `c_ready_o` is 0.
- R2: A beat is taken only from the controller named in `req_target_i` of the oldest unfinished descriptor. At most one `c_ready_o` bit is high, and it belongs to that controller.
- R3: A descriptor with `req_beats_i`=k covers exactly k+1 beats (k from 0 to 2^CNT_W-1). These beats are forwarded in arrival order, and then the next descriptor takes over. Data is passed unchanged.
- R4: `m_last_o` is 1 only on the closing beat of a descriptor whose `req_final_i`=1. The last flags on `c_last_i` are never forwarded.
- R5: Response codes are 0 OKAY, 1 EXOKAY, 2 SLVERR and 3 DECERR, and a larger code is worse. `m_resp_o` on each beat is the worst code seen from the burst's first beat up to and including the current one. The next burst starts again from OKAY.
- R6: `err_o` becomes 1 after an accepted beat whose `c_last_i` disagrees with the descriptor's closing beat. Once set, it stays 1 until reset.
- R7: The descriptor queue holds DEPTH entries. `req_ready_o` is 0 while DEPTH entries are pending, and it stays 0 until an entry retires.
- R8: With no descriptor pending, `m_valid_o` and `c_ready_o` stay 0 whatever the controllers present.
- R9: While `m_ready_i`=0, no `c_ready_o` bit is high, so no controller beat is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Piece descriptor valid |
| req_ready_o | output | 1 | Descriptor queue has room |
| req_target_i | input | TGT_W | Controller that returns this piece |
| req_beats_i | input | CNT_W | Beat count of the piece minus one |
| req_final_i | input | 1 | Piece closes the master burst |
| c_valid_i | input | N_CTRL | Per-controller beat valid |
| c_ready_o | output | N_CTRL | Per-controller beat accept |
| c_data_i | input | N_CTRL*DATA_W | Per-controller beat data, controller i at bits i*DATA_W upward |
| c_resp_i | input | N_CTRL*2 | Per-controller response code |
| c_last_i | input | N_CTRL | Per-controller last flag of its piece |
| m_valid_o | output | 1 | Master beat valid |
| m_ready_i | input | 1 | Master accepts beat |
| m_data_o | output | DATA_W | Master beat data |
| m_resp_o | output | 2 | Accumulated worst response code |
| m_last_o | output | 1 | Final beat of the master burst |
| err_o | output | 1 | Sticky beat-count mismatch flag |

## Verification
The assertions check on every cycle that at most one controller is granted, that an output handshake consumes exactly one controller beat, and that a stalled master consumes nothing. They also check that the error flag never clears, that an error code stays in the accumulated response for the rest of the burst, and that a full queue stays full until a piece retires. Some behaviours only the bench scenarios can show, because they need a model of the whole burst: the beat order across interleaved controllers, the placement of the single last marker, and the exact response value on each beat. The same applies to the longest piece length, the overflowing descriptor queue, and raising the error flag from a misplaced controller last flag.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef logic [1:0] resp_t;
  localparam resp_t RESP_OKAY   = 2'd0;
  localparam resp_t RESP_EXOKAY = 2'd1;
  localparam resp_t RESP_SLVERR = 2'd2;
  localparam resp_t RESP_DECERR = 2'd3;

  function automatic resp_t resp_worst(resp_t a, resp_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/merge_req_fifo.sv
module merge_req_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [AW:0]      cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/merge_beat_mux.sv
module merge_beat_mux
  import merge_pkg::*;
#(
  parameter int N_CTRL = 4,
  parameter int DATA_W = 32,
  parameter int TGT_W  = 2
) (
  input  logic                     head_vld_i,
  input  logic [TGT_W-1:0]         sel_i,
  input  logic                     m_ready_i,
  input  logic [N_CTRL-1:0]        c_valid_i,
  input  logic [N_CTRL*DATA_W-1:0] c_data_i,
  input  logic [N_CTRL*2-1:0]      c_resp_i,
  input  logic [N_CTRL-1:0]        c_last_i,
  output logic [N_CTRL-1:0]        c_ready_o,
  output logic                     sel_valid_o,
  output logic [DATA_W-1:0]        sel_data_o,
  output resp_t                    sel_resp_o,
  output logic                     sel_last_o
);
  logic [DATA_W-1:0] data_arr [N_CTRL];
  resp_t             resp_arr [N_CTRL];
  logic [N_CTRL-1:0] hit;

  for (genvar i = 0; i < N_CTRL; i++) begin : g_ch
    assign data_arr[i]  = c_data_i[i*DATA_W +: DATA_W];
    assign resp_arr[i]  = c_resp_i[i*2 +: 2];
    assign hit[i]       = head_vld_i && (sel_i == TGT_W'(i));
    assign c_ready_o[i] = hit[i] && m_ready_i;
  end

  always_comb begin
    sel_valid_o = 1'b0;
    sel_data_o  = '0;
    sel_resp_o  = RESP_OKAY;
    sel_last_o  = 1'b0;
    for (int i = 0; i < N_CTRL; i++) begin
      if (hit[i]) begin
        sel_valid_o = c_valid_i[i];
        sel_data_o  = data_arr[i];
        sel_resp_o  = resp_arr[i];
        sel_last_o  = c_last_i[i];
      end
    end
  end
endmodule

// File: rtl/merge_piece_track.sv
module merge_piece_track
  import merge_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] beats_m1_i,
  input  logic             final_i,
  input  resp_t            beat_resp_i,
  input  logic             beat_last_i,
  output logic             piece_end_o,
  output logic             last_o,
  output resp_t            resp_o,
  output logic             err_o
);
  logic [CNT_W-1:0] beat_q;
  resp_t            acc_q;
  logic             err_q;

  assign piece_end_o = (beat_q == beats_m1_i);
  assign last_o      = final_i && piece_end_o;
  assign resp_o      = resp_worst(acc_q, beat_resp_i);
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      acc_q  <= RESP_OKAY;
      err_q  <= 1'b0;
    end else if (fire_i) begin
      beat_q <= piece_end_o ? '0 : beat_q + 1'b1;
      acc_q  <= last_o ? RESP_OKAY : resp_o;
      // controller's own piece length must agree with the descriptor
      if (beat_last_i != piece_end_o) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/split_read_merger.sv
module split_read_merger
  import merge_pkg::*;
#(
  parameter int N_CTRL = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  parameter int DEPTH  = 4,
  localparam int TGT_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [TGT_W-1:0]         req_target_i,
  input  logic [CNT_W-1:0]         req_beats_i,
  input  logic                     req_final_i,
  input  logic [N_CTRL-1:0]        c_valid_i,
  output logic [N_CTRL-1:0]        c_ready_o,
  input  logic [N_CTRL*DATA_W-1:0] c_data_i,
  input  logic [N_CTRL*2-1:0]      c_resp_i,
  input  logic [N_CTRL-1:0]        c_last_i,
  output logic                     m_valid_o,
  input  logic                     m_ready_i,
  output logic [DATA_W-1:0]        m_data_o,
  output logic [1:0]               m_resp_o,
  output logic                     m_last_o,
  output logic                     err_o
);
  localparam int ENTRY_W = TGT_W + CNT_W + 1;

  logic [ENTRY_W-1:0] head;
  logic               empty, full, fire, piece_end;
  logic [TGT_W-1:0]   head_tgt;
  logic [CNT_W-1:0]   head_beats;
  logic               head_final;
  logic               sel_valid, sel_last;
  resp_t              sel_resp, out_resp;

  assign req_ready_o = !full;
  assign {head_final, head_beats, head_tgt} = head;

  merge_req_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (req_valid_i),
    .din_i   ({req_final_i, req_beats_i, req_target_i}),
    .pop_i   (fire && piece_end),
    .dout_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  merge_beat_mux #(.N_CTRL(N_CTRL), .DATA_W(DATA_W), .TGT_W(TGT_W)) i_mux (
    .head_vld_i  (!empty),
    .sel_i       (head_tgt),
    .m_ready_i   (m_ready_i),
    .c_valid_i   (c_valid_i),
    .c_data_i    (c_data_i),
    .c_resp_i    (c_resp_i),
    .c_last_i    (c_last_i),
    .c_ready_o   (c_ready_o),
    .sel_valid_o (sel_valid),
    .sel_data_o  (m_data_o),
    .sel_resp_o  (sel_resp),
    .sel_last_o  (sel_last)
  );

  assign m_valid_o = !empty && sel_valid;
  assign fire      = m_valid_o && m_ready_i;

  merge_piece_track #(.CNT_W(CNT_W)) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .beats_m1_i  (head_beats),
    .final_i     (head_final),
    .beat_resp_i (sel_resp),
    .beat_last_i (sel_last),
    .piece_end_o (piece_end),
    .last_o      (m_last_o),
    .resp_o      (out_resp),
    .err_o       (err_o)
  );

  assign m_resp_o = out_resp;
endmodule

// File: rtl/split_read_merger_chk.sv
module split_read_merger_chk #(
  parameter int N_CTRL = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic [N_CTRL-1:0] c_valid_i,
  input logic [N_CTRL-1:0] c_ready_o,
  input logic              m_valid_o,
  input logic              m_ready_i,
  input logic [1:0]        m_resp_o,
  input logic              m_last_o,
  input logic              err_o
);
  a_r2_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(c_ready_o));

  a_r2_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_ready_i) |-> ($countones(c_ready_o & c_valid_i) == 1));

  a_r9_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_ready_i |-> (c_ready_o == '0));

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r5_error_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_ready_i && !m_last_o && m_resp_o[1]) |=> m_resp_o[1]);

  a_r7_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !(m_valid_o && m_ready_i)) |=> !req_ready_o);
endmodule

bind split_read_merger split_read_merger_chk #(.N_CTRL(N_CTRL)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .c_valid_i   (c_valid_i),
  .c_ready_o   (c_ready_o),
  .m_valid_o   (m_valid_o),
  .m_ready_i   (m_ready_i),
  .m_resp_o    (m_resp_o),
  .m_last_o    (m_last_o),
  .err_o       (err_o)
);

// File: tb/test_split_read_merger.sv
`timescale 1ns/1ps
module test_split_read_merger;
  localparam int N = 4, DW = 32, CW = 4, DEP = 4, TW = 2;
  localparam int MAXB = 4096, MAXR = 1024;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic           req_valid_i = 1'b0, req_ready_o, req_final_i = 1'b0;
  logic [TW-1:0]  req_target_i = '0;
  logic [CW-1:0]  req_beats_i = '0;
  logic [N-1:0]   c_valid_i = '0, c_ready_o, c_last_i = '0;
  logic [N*DW-1:0] c_data_i = '0;
  logic [N*2-1:0] c_resp_i = '0;
  logic           m_valid_o, m_ready_i = 1'b0, m_last_o, err_o;
  logic [DW-1:0]  m_data_o;
  logic [1:0]     m_resp_o;

  split_read_merger #(.N_CTRL(N), .DATA_W(DW), .CNT_W(CW), .DEPTH(DEP)) i_split_read_merger (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_target_i(req_target_i),
    .req_beats_i(req_beats_i), .req_final_i(req_final_i),
    .c_valid_i(c_valid_i), .c_ready_o(c_ready_o), .c_data_i(c_data_i),
    .c_resp_i(c_resp_i), .c_last_i(c_last_i),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_data_o(m_data_o),
    .m_resp_o(m_resp_o), .m_last_o(m_last_o), .err_o(err_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  int unsigned c_d [N][MAXB];
  logic [1:0]  c_r [N][MAXB];
  bit          c_l [N][MAXB];
  int          c_cnt [N], c_ptr [N];
  int unsigned o_d [MAXB];
  logic [1:0]  o_r [MAXB];
  bit          o_l [MAXB];
  int          o_c [MAXB];
  int          o_cnt, o_ptr;
  int          r_t [MAXR], r_b [MAXR];
  bit          r_f [MAXR];
  int          r_cnt, r_ptr;
  logic [1:0]  run_worst;
  int unsigned seq = 32'h100;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_scn();
    for (int i = 0; i < N; i++) begin c_cnt[i] = 0; c_ptr[i] = 0; end
    o_cnt = 0; o_ptr = 0; r_cnt = 0; r_ptr = 0; run_worst = 2'd0;
  endtask

  // rsp_fix < 0 picks random codes; bad_last moves the controller last flag to beat 0
  task automatic add_piece(int ctrl, int nb, bit fin, int rsp_fix, bit bad_last);
    logic [1:0] rsp;
    r_t[r_cnt] = ctrl; r_b[r_cnt] = nb - 1; r_f[r_cnt] = fin; r_cnt++;
    for (int b = 0; b < nb; b++) begin
      seq++;
      if (rsp_fix >= 0) rsp = 2'(rsp_fix);
      else begin
        int x = $urandom_range(0, 11);
        rsp = (x >= 9) ? 2'(x - 8) : 2'd0;
      end
      c_d[ctrl][c_cnt[ctrl]] = seq;
      c_r[ctrl][c_cnt[ctrl]] = rsp;
      c_l[ctrl][c_cnt[ctrl]] = bad_last ? (b == 0) : (b == nb - 1);
      c_cnt[ctrl]++;
      if (rsp > run_worst) run_worst = rsp;
      o_d[o_cnt] = seq; o_r[o_cnt] = run_worst;
      o_l[o_cnt] = fin && (b == nb - 1); o_c[o_cnt] = ctrl; o_cnt++;
    end
    if (fin) run_worst = 2'd0;
  endtask

  task automatic run_scn(int hold, int vprob, int mprob);
    int cyc = 0;
    bit stall_bad = 0, sel_bad = 0;
    while ((o_ptr < o_cnt || r_ptr < r_cnt) && cyc < 20000) begin
      @(negedge clk_i);
      cyc++;
      req_valid_i = (r_ptr < r_cnt) && (cyc <= hold || $urandom_range(0, 99) < 80);
      if (r_ptr < r_cnt) begin
        req_target_i = TW'(r_t[r_ptr]); req_beats_i = CW'(r_b[r_ptr]); req_final_i = r_f[r_ptr];
      end
      for (int i = 0; i < N; i++) begin
        c_valid_i[i] = (cyc > hold) && (c_ptr[i] < c_cnt[i]) && ($urandom_range(0, 99) < vprob);
        if (c_ptr[i] < c_cnt[i]) begin
          c_data_i[i*DW +: DW] = c_d[i][c_ptr[i]];
          c_resp_i[i*2 +: 2]   = c_r[i][c_ptr[i]];
          c_last_i[i]          = c_l[i][c_ptr[i]];
        end
      end
      m_ready_i = ($urandom_range(0, 99) < mprob);
      #1;
      if (hold > 0 && cyc == hold)
        chk(req_ready_o == 1'b0, "R7", "queue full", req_ready_o, 0);
      if (!m_ready_i && c_ready_o != '0) stall_bad = 1;
      if (m_ready_i && o_ptr < o_cnt && (c_ready_o & ~(N'(1) << o_c[o_ptr])) != '0) sel_bad = 1;
      if (m_valid_o && m_ready_i) begin
        if (o_ptr >= o_cnt) chk(0, "R2", "extra beat", m_data_o, 0);
        else begin
          chk(m_data_o == o_d[o_ptr], "R3", "beat data/order", m_data_o, o_d[o_ptr]);
          chk(m_resp_o == o_r[o_ptr], "R5", "response", m_resp_o, o_r[o_ptr]);
          chk(m_last_o == o_l[o_ptr], "R4", "last marker", m_last_o, o_l[o_ptr]);
          chk((c_valid_i & c_ready_o) == (N'(1) << o_c[o_ptr]), "R2", "source controller",
              c_valid_i & c_ready_o, N'(1) << o_c[o_ptr]);
          c_ptr[o_c[o_ptr]]++;
          o_ptr++;
        end
      end
      if (req_valid_i && req_ready_o) r_ptr++;
    end
    chk(cyc < 20000, "R3", "scenario drained", cyc, 0);
    chk(!stall_bad, "R9", "grant while master stalled", stall_bad, 0);
    chk(!sel_bad, "R2", "grant to non-head controller", sel_bad, 0);
    @(negedge clk_i);
    c_valid_i = '0; req_valid_i = 1'b0; m_ready_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    #10;
    chk(m_valid_o == 0, "R1", "m_valid in reset", m_valid_o, 0);
    chk(err_o == 0, "R1", "err in reset", err_o, 0);
    chk(req_ready_o == 1, "R1", "req_ready in reset", req_ready_o, 1);
    chk(c_ready_o == '0, "R1", "c_ready in reset", c_ready_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R8: controllers offer data with no descriptor pending
    @(negedge clk_i);
    c_valid_i = '1; m_ready_i = 1'b1;
    #1;
    chk(m_valid_o == 0, "R8", "m_valid with empty queue", m_valid_o, 0);
    chk(c_ready_o == '0, "R8", "c_ready with empty queue", c_ready_o, 0);
    @(negedge clk_i);
    c_valid_i = '0; m_ready_i = 1'b0;

    // R3: longest piece, 16 beats from one controller
    clear_scn();
    add_piece(2, 16, 1, -1, 0);
    run_scn(0, 100, 100);

    // R7: more single-beat pieces than queue slots, controllers held off
    clear_scn();
    add_piece(3, 1, 0, 0, 0); add_piece(0, 1, 0, 0, 0); add_piece(1, 1, 0, 0, 0);
    add_piece(2, 1, 0, 0, 0); add_piece(0, 1, 1, 0, 0);
    run_scn(30, 100, 100);

    // R5: error precedence and restart at the next burst
    clear_scn();
    add_piece(1, 2, 0, 0, 0); add_piece(0, 2, 0, 2, 0); add_piece(1, 2, 1, 1, 0);
    add_piece(3, 2, 1, 0, 0);
    run_scn(0, 70, 80);

    // random interleaved bursts
    clear_scn();
    for (int b = 0; b < 60; b++) begin
      int np = $urandom_range(1, 4);
      for (int p = 0; p < np; p++)
        add_piece($urandom_range(0, N - 1), $urandom_range(1, 6), p == np - 1, -1, 0);
    end
    run_scn(0, 60, 70);
    chk(err_o == 0, "R6", "no error on consistent traffic", err_o, 0);

    // R6: controller ends its piece one beat early
    clear_scn();
    add_piece(0, 1, 0, 0, 0); add_piece(1, 2, 1, 0, 1);
    run_scn(0, 100, 100);
    chk(err_o == 1, "R6", "mismatch flagged", err_o, 1);
    clear_scn();
    add_piece(2, 3, 1, -1, 0);
    run_scn(0, 80, 80);
    chk(err_o == 1, "R6", "flag sticky", err_o, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule